// File: doc/BRIEF.md
# Crosspoint-Buffered Crossbar Cell Switch

This block is an N-by-N cell switch. Every input places its cell on its own row. Each input–output pair has a crosspoint with two parts: an address filter and a small private FIFO. A crosspoint keeps a copy of the row's cell only when the cell's destination field names that crosspoint's column. No crosspoint needs to know anything about the other cells, so routing is decided locally by each crosspoint.

Each output column has a round-robin arbiter. On every cell slot it takes at most one cell from the non-empty FIFOs in its column and sends it out. The queue for an output is therefore spread across N independent crosspoint buffers that share no storage. Each buffer has its own write port, so several inputs can load the same column in the same slot.

A slot strobe marks the cycles in which cells move. When a cell reaches a full crosspoint buffer, the cell is discarded and that crosspoint reports an overflow.

Each column arbiter is a two-state machine:
- State `COL_QUIET` means no cell is being presented.
- State `COL_EMIT` means a cell is presented for one cycle.
- The transition QUIET/EMIT→EMIT ("grant") happens on a slot edge at which some buffer in the column is non-empty.
- Every other edge takes the "release" transition back to QUIET.

Top module: `xbar_cell_switch`

## Requirements
- R1: While reset is held and just after it is released, every `out_valid` bit and every `xp_overflow` bit is 0, and all crosspoint buffers are empty.
- R2: A cell that input i presents with destination d, with `in_valid` set, in a slot cycle is captured only by crosspoint (i,d). It can appear only on output d.
- R3: Cells from several inputs that name the same output in one slot are all stored, up to buffer room, and all of them are delivered in later slots.
- R4: An output carries at most one cell per slot. `out_valid[j]` is a single-cycle pulse in the cycle that follows a slot-strobe edge, and it is 0 in every other cycle.
- R5 (work conservation): If any buffer in column j holds a cell at a slot edge, then `out_valid[j]` is 1 in the following cycle.
- R6: Column arbitration is round-robin. The search starts at the row one past the last granted row (row 0 after reset) and takes the first non-empty row in increasing order, wrapping around.
- R7: Cells that pass through one crosspoint leave in the order they arrived.
- R8: A cell that meets a full crosspoint is dropped. The crosspoint's overflow bit, `xp_overflow[i*N+d]`, then pulses in the cycle after the slot. A departure from that crosspoint in the same slot frees room first, so in that case the cell is accepted.
- R9: A cell accepted in a slot is not eligible before the next slot. Inputs are ignored in cycles where `slot` is 0, and a cell with `in_valid` at 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot | input | 1 | Cell slot strobe; cells move on edges where this is 1 |
| in_valid | input | N | Per-input cell present |
| in_data | input | N*W | Per-input cell payload, input i at bits [i*W +: W] |
| in_dest | input | N*DW | Per-input destination port, DW = clog2(N), input i at [i*DW +: DW] |
| out_valid | output | N | Per-output cell present (one-cycle pulse) |
| out_data | output | N*W | Per-output cell payload, output j at [j*W +: W] |
| xp_overflow | output | N*N | Per-crosspoint drop pulse, crosspoint (i,j) at bit i*N+j |

## Verification
The bench fills one column from all four inputs until the crosspoint buffers overflow. A design that tested fullness without counting the departure in the same slot would report drops that should not happen. One that wrote into a full buffer would lose older cells or reorder them.

Bursts that share a destination exercise the round-robin pointer. A pointer that did not advance past the granted row would starve the higher rows and break the expected output order.

Live-looking inputs are held on the ports between slots. A filter that did not qualify on the strobe would capture them twice. Random traffic then checks every output and overflow bit against a per-crosspoint queue model in each slot.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
    typedef enum logic {
        COL_QUIET = 1'b0,
        COL_EMIT  = 1'b1
    } col_state_e;

    function automatic int wrap_next(input int idx, input int lim);
        return (idx + 1 >= lim) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/xbs_xp_fifo.sv
module xbs_xp_fifo #(
    parameter int W     = 16,
    parameter int DW    = 2,
    parameter int DEPTH = 4,
    parameter int COL   = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot,
    input  logic          in_valid,
    input  logic [DW-1:0] in_dest,
    input  logic [W-1:0]  in_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          not_empty,
    output logic          overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          hit, room, wr;

    assign hit  = slot && in_valid && (in_dest == DW'(COL));
    assign room = (cnt != CW'(DEPTH)) || pop;
    assign wr   = hit && room;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            overflow <= hit && !room;
            if (wr)  wr_ptr <= bump(wr_ptr);
            if (pop) rd_ptr <= bump(rd_ptr);
            unique case ({wr, pop})
                2'b10:   cnt <= cnt + CW'(1);
                2'b01:   cnt <= cnt - CW'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (wr) mem[wr_ptr] <= in_data;
    end

    assign head      = mem[rd_ptr];
    assign not_empty = (cnt != '0);

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    assert_drop_only_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && !pop && cnt != CW'(DEPTH)) |=> !overflow);
    assert_filter_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(slot && in_valid && in_dest == DW'(COL)) |=> cnt <= $past(cnt));
    assert_pop_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> not_empty);
endmodule

// File: rtl/xbs_col_arb.sv
module xbs_col_arb
    import xbs_pkg::*;
#(
    parameter int N = 4,
    parameter int W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                slot,
    input  logic [N-1:0]        req,
    input  logic [N-1:0][W-1:0] heads,
    output logic [N-1:0]        pop,
    output logic                out_valid,
    output logic [W-1:0]        out_data
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    col_state_e    state, state_nx;
    logic [PW-1:0] ptr;
    logic          found;
    logic [PW-1:0] gidx;

    always_comb begin
        int idx;
        found = 1'b0;
        gidx  = '0;
        for (int k = 0; k < N; k++) begin
            idx = int'(ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!found && req[idx]) begin
                found = 1'b1;
                gidx  = PW'(idx);
            end
        end
    end

    always_comb begin
        pop = '0;
        if (slot && found) pop[gidx] = 1'b1;
    end

    always_comb begin
        unique case (state)
            COL_QUIET: state_nx = (slot && found) ? COL_EMIT : COL_QUIET;
            COL_EMIT:  state_nx = (slot && found) ? COL_EMIT : COL_QUIET;
            default:   state_nx = COL_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= COL_QUIET;
            ptr      <= '0;
            out_data <= '0;
        end else begin
            state <= state_nx;
            if (slot && found) begin
                out_data <= heads[gidx];
                ptr      <= PW'(wrap_next(int'(gidx), N));
            end
        end
    end

    always_comb begin
        out_valid = (state == COL_EMIT);
    end

    assert_one_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pop));
    assert_pulse_after_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(slot));
    assert_work_conserving_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && (|req)) |=> out_valid);
    assert_rr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (slot && found) |=> ptr == PW'(wrap_next(int'($past(gidx)), N)));
endmodule

// File: rtl/xbar_cell_switch.sv
module xbar_cell_switch #(
    parameter int N     = 4,
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int DW   = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            slot,
    input  logic [N-1:0]    in_valid,
    input  logic [N*W-1:0]  in_data,
    input  logic [N*DW-1:0] in_dest,
    output logic [N-1:0]    out_valid,
    output logic [N*W-1:0]  out_data,
    output logic [N*N-1:0]  xp_overflow
);
    logic [N-1:0]        ne_col   [N];
    logic [N-1:0]        pop_col  [N];
    logic [N-1:0][W-1:0] head_col [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_xp
            xbs_xp_fifo #(.W(W), .DW(DW), .DEPTH(DEPTH), .COL(j)) u_xp (
                .clk       (clk),
                .rst_n     (rst_n),
                .slot      (slot),
                .in_valid  (in_valid[i]),
                .in_dest   (in_dest[i*DW +: DW]),
                .in_data   (in_data[i*W +: W]),
                .pop       (pop_col[j][i]),
                .head      (head_col[j][i]),
                .not_empty (ne_col[j][i]),
                .overflow  (xp_overflow[i*N + j])
            );
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_col
        xbs_col_arb #(.N(N), .W(W)) u_arb (
            .clk       (clk),
            .rst_n     (rst_n),
            .slot      (slot),
            .req       (ne_col[j]),
            .heads     (head_col[j]),
            .pop       (pop_col[j]),
            .out_valid (out_valid[j]),
            .out_data  (out_data[j*W +: W])
        );
    end
endmodule

// File: tb/xbar_cell_switch_bench.sv
module xbar_cell_switch_bench;
    localparam int N = 4, W = 16, DEPTH = 4, DW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            slot = 1'b0;
    logic [N-1:0]    in_valid = '0;
    logic [N*W-1:0]  in_data = '0;
    logic [N*DW-1:0] in_dest = '0;
    logic [N-1:0]    out_valid;
    logic [N*W-1:0]  out_data;
    logic [N*N-1:0]  xp_overflow;

    always #2 clk = ~clk;

    xbar_cell_switch #(.N(N), .W(W), .DEPTH(DEPTH)) u_xbar_cell_switch (
        .clk(clk), .rst_n(rst_n), .slot(slot), .in_valid(in_valid),
        .in_data(in_data), .in_dest(in_dest), .out_valid(out_valid),
        .out_data(out_data), .xp_overflow(xp_overflow));

    int n_cmp = 0, n_bad = 0;
    logic [W-1:0] mq [N][N][DEPTH];
    int mcnt [N][N];
    int mptr [N];
    logic [N-1:0]   exp_v;
    logic [W-1:0]   exp_d [N];
    logic [N*N-1:0] exp_ovf;
    logic [N-1:0]   sv;
    int             sdst [N];
    logic [W-1:0]   sdat [N];
    logic [W-1:0]   tagc = 16'h0100;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic model_slot();
        exp_v = '0; exp_ovf = '0;
        for (int j = 0; j < N; j++) begin
            exp_d[j] = '0;
            for (int k = 0; k < N; k++) begin
                int r;
                r = (mptr[j] + k) % N;
                if (!exp_v[j] && mcnt[r][j] > 0) begin
                    exp_v[j] = 1'b1;
                    exp_d[j] = mq[r][j][0];
                    for (int q = 0; q < DEPTH - 1; q++) mq[r][j][q] = mq[r][j][q+1];
                    mcnt[r][j]--;
                    mptr[j] = (r + 1) % N;
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            if (sv[i]) begin
                if (mcnt[i][sdst[i]] < DEPTH) begin
                    mq[i][sdst[i]][mcnt[i][sdst[i]]] = sdat[i];
                    mcnt[i][sdst[i]]++;
                end else exp_ovf[i*N + sdst[i]] = 1'b1;
            end
        end
    endtask

    // One slot: drive at negedge, edge, compare at next negedge, then leave junk on the inputs
    task automatic do_slot();
        @(negedge clk);
        slot = 1'b1;
        for (int i = 0; i < N; i++) begin
            in_valid[i] = sv[i];
            in_dest[i*DW +: DW] = DW'(sdst[i]);
            in_data[i*W +: W] = sdat[i];
        end
        model_slot();
        @(negedge clk);
        slot = 1'b0;
        for (int j = 0; j < N; j++) begin
            chk(out_valid[j] == exp_v[j], "R5 R3 out_valid", 64'(out_valid[j]), 64'(exp_v[j]));
            if (exp_v[j])
                chk(out_data[j*W +: W] == exp_d[j], "R2 R6 R7 out_data",
                    64'(out_data[j*W +: W]), 64'(exp_d[j]));
        end
        chk(xp_overflow == exp_ovf, "R8 xp_overflow", 64'(xp_overflow), 64'(exp_ovf));
        in_valid = '1;
        in_data  = {N{16'hDEAD}};
        in_dest  = '0;
    endtask

    // A gap cycle without strobe: outputs must be quiet, junk inputs must not be captured (R9)
    task automatic gap();
        @(negedge clk);
        chk(out_valid == '0, "R4 R9 no pulse outside slot", 64'(out_valid), 0);
        chk(xp_overflow == '0, "R4 overflow quiet", 64'(xp_overflow), 0);
    endtask

    task automatic idle_slots(input int n);
        for (int s = 0; s < n; s++) begin
            sv = '0;
            do_slot();
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < N; i++) begin
            mptr[i] = 0;
            for (int j = 0; j < N; j++) mcnt[i][j] = 0;
        end
        repeat (4) @(negedge clk);
        chk(out_valid == '0, "R1 out_valid in reset", 64'(out_valid), 0);
        chk(xp_overflow == '0, "R1 overflow in reset", 64'(xp_overflow), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == '0, "R1 out_valid after reset", 64'(out_valid), 0);
        // R1: empty buffers give nothing on the first slot
        idle_slots(1);

        // R2: one cell per output, distinct destinations
        for (int i = 0; i < N; i++) begin
            sv[i] = 1'b1; sdst[i] = (i + 1) % N; sdat[i] = tagc; tagc++;
        end
        do_slot();
        gap();
        idle_slots(2);

        // R3 R6: all inputs to output 2, several slots, round-robin order
        for (int s = 0; s < 3; s++) begin
            for (int i = 0; i < N; i++) begin
                sv[i] = 1'b1; sdst[i] = 2; sdat[i] = tagc; tagc++;
            end
            do_slot();
        end
        idle_slots(12);

        // R8: flood output 1 from all rows until crosspoints overflow
        for (int s = 0; s < 8; s++) begin
            for (int i = 0; i < N; i++) begin
                sv[i] = 1'b1; sdst[i] = 1; sdat[i] = tagc; tagc++;
            end
            do_slot();
        end
        idle_slots(20);

        // R7 R9: single row streaming with slot gaps
        for (int s = 0; s < 6; s++) begin
            sv = 4'b0001; sdst[0] = 3; sdat[0] = tagc; tagc++;
            do_slot();
            gap();
        end
        idle_slots(4);

        // Random traffic
        for (int s = 0; s < 400; s++) begin
            for (int i = 0; i < N; i++) begin
                sv[i] = ($urandom % 3) != 0;
                sdst[i] = int'($urandom % N);
                sdat[i] = tagc; tagc++;
            end
            if (($urandom % 4) == 0) sdst = '{0, 0, 0, 0};
            do_slot();
            if (($urandom % 3) == 0) gap();
        end
        idle_slots(24);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule